// File: doc/BRIEF.md
# Cross-Domain Bit-Enabled Counter

This block keeps a free-running counter in a destination clock domain and lets a second, unrelated write clock domain turn the counting on and off. The write domain owns a single control bit, which it loads through a write enable and a data bit. The bit crosses into the destination domain through a bit synchronizer. The synchronizer has one flop in the write domain and two flops in the destination domain. Nothing combinational sits between the write-domain flop and the first destination flop, and only the last destination flop is read.

Each domain has its own asynchronous active-low reset. Only one bit crosses, so the enable is a level and not an event. A level held for less than a destination period could be lost if the write clock were faster than the destination clock. The counter width is a parameter, 32 by default, and the counter wraps silently.

Top module: `xdom_counter`

## Requirements
- R1: The write-domain control bit and the write-domain synchronizer flop reset to 0 while wr_rst_n is low, independently of any clock.
- R2: count is 0 while dst_rst_n is low. If the control bit is 1 when dst_rst_n is released (released between destination edges), count first becomes 1 on the third destination rising edge after release.
- R3: On a write rising edge with wr_en high, the control bit takes the value of wr_bit. When wr_en is low, wr_bit has no effect on the control bit and so none on count.
- R4: On every destination rising edge, count rises by exactly one (modulo 2^CNT_W) if the synchronized bit is 1 and holds otherwise.
- R5: The write period lies between one and two destination periods. After the write edge that loads 0, count rises 3 or 4 more times and then holds.
- R6: With the same clock ratio, after the write edge that loads 1, count first changes on the fourth or fifth destination rising edge.
- R7: Asserting wr_rst_n while counting stops count within at most two further increments, and count is not cleared.
- R8: A control bit that is 1 for exactly one write cycle, with the write period between one and two destination periods, makes count rise by 1 or 2 in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| wr_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| wr_en | input | 1 | Load strobe for the control bit |
| wr_bit | input | 1 | New value of the control bit |
| dst_clk | input | 1 | Destination-domain clock |
| dst_rst_n | input | 1 | Destination-domain asynchronous reset, active low |
| count | output | CNT_W | Counter value, destination domain |

## Verification
A change to the control bit is due at count after the load edge, one more write edge at the synchronizer's source flop, and three destination edges: two synchronizer stages and the counter. The two clocks are asynchronous, so the first of these spans one or two destination edges. The bench counts destination edges from the write edge that carries a stimulus and samples count one nanosecond after each of them. Every latency check accepts exactly the window that this ratio allows. After a destination reset the path is fully synchronous, so the bench checks the exact edge at which count first becomes 1.

// File: rtl/xdom_counter.sv
module xdom_counter #(
  parameter int CNT_W = 32
) (
  input  logic             wr_clk,
  input  logic             wr_rst_n,
  input  logic             wr_en,
  input  logic             wr_bit,
  input  logic             dst_clk,
  input  logic             dst_rst_n,
  output logic [CNT_W-1:0] count
);

  logic ctrl_q;
  logic src_q;
  logic meta_q;
  logic sync_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      ctrl_q <= 1'b0;
      src_q  <= 1'b0;
    end else begin
      if (wr_en) ctrl_q <= wr_bit;
      src_q <= ctrl_q;
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= src_q;
      sync_q <= meta_q;
    end
  end

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) cnt_q <= '0;
    else if (sync_q) cnt_q <= cnt_q + CNT_W'(1);
  end

  assign count = cnt_q;

  AST_CTRL_HOLD: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !$past(wr_en) |-> $stable(ctrl_q)); // R3

  AST_STEP_LE_ONE: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (count - $past(count)) <= CNT_W'(1)); // R4

  AST_HOLD_WHEN_OFF: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    !sync_q |=> $stable(count)); // R4

  AST_CNT_NEEDS_META: assert property (@(posedge dst_clk) disable iff (!dst_rst_n)
    (count != $past(count)) |-> $past(meta_q, 2)); // R6

endmodule

// File: tb/xdom_counter_tb_top.sv
module xdom_counter_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic wr_clk = 1'b0;
  logic dst_clk = 1'b0;
  logic wr_rst_n = 1'b0;
  logic dst_rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic wr_bit = 1'b0;
  logic [31:0] count;

  int n_chk = 0;
  int n_fail = 0;

  always #6.5 wr_clk = ~wr_clk;
  always #4 dst_clk = ~dst_clk;

  xdom_counter #(.CNT_W(32)) dut_i (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .dst_clk(dst_clk), .dst_rst_n(dst_rst_n), .count(count)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic dst_edge();
    @(posedge dst_clk);
    #1;
  endtask

  task automatic load(input logic b);
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_bit = b;
    @(posedge wr_clk);
  endtask

  task automatic drop_en();
    @(negedge wr_clk);
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    wr_bit = 1'b1;
    repeat (5) dst_edge();
    chk(count == 0, "R2 count in reset", count, 0);
    @(negedge wr_clk) wr_rst_n = 1'b1;
    @(negedge dst_clk) dst_rst_n = 1'b1;
    repeat (12) dst_edge();
    chk(count == 0, "R1 R3 bit reset and wr_bit ignored", count, 0);
    wr_bit = 1'b0;
  endtask

  task automatic t_set();
    logic [31:0] c0;
    int first = 0;
    load(1'b1);
    c0 = count;
    for (int i = 1; i <= 10; i++) begin
      dst_edge();
      if (first == 0 && count != c0) first = i;
    end
    chk(first == 4 || first == 5, "R6 start latency edges", first, 4);
    drop_en();
  endtask

  task automatic t_steady_ignore();
    logic [31:0] c0;
    dst_edge();
    c0 = count;
    repeat (20) dst_edge();
    chk(count - c0 == 20, "R4 steady increments", count - c0, 20);
    @(negedge wr_clk) wr_bit = 1'b0;
    dst_edge();
    c0 = count;
    repeat (24) dst_edge();
    chk(count - c0 == 24, "R3 wr_bit ignored while counting", count - c0, 24);
  endtask

  task automatic t_clear();
    logic [31:0] c0;
    logic [31:0] c1;
    load(1'b0);
    c0 = count;
    repeat (12) dst_edge();
    chk(count - c0 == 3 || count - c0 == 4, "R5 increments after clear", count - c0, 3);
    c1 = count;
    repeat (20) dst_edge();
    chk(count == c1, "R4 holds while bit is 0", count, c1);
    drop_en();
    wr_bit = 1'b1;
    repeat (10) @(posedge wr_clk);
    repeat (6) dst_edge();
    chk(count == c1, "R3 wr_bit ignored while idle", count, c1);
    wr_bit = 1'b0;
  endtask

  task automatic t_pulse();
    logic [31:0] c0;
    c0 = count;
    @(negedge wr_clk);
    wr_en = 1'b1;
    wr_bit = 1'b1;
    @(negedge wr_clk);
    wr_bit = 1'b0;
    @(negedge wr_clk);
    wr_en = 1'b0;
    repeat (15) dst_edge();
    chk(count - c0 == 1 || count - c0 == 2, "R8 one-cycle pulse increments", count - c0, 1);
  endtask

  task automatic t_wr_reset();
    logic [31:0] c0;
    logic [31:0] c1;
    load(1'b1);
    drop_en();
    repeat (15) dst_edge();
    #1 wr_rst_n = 1'b0;
    c0 = count;
    repeat (10) dst_edge();
    chk(count - c0 <= 2, "R7 stop after write reset", count - c0, 2);
    chk(count >= c0 && count != 0, "R7 count not cleared", count, c0);
    c1 = count;
    repeat (10) dst_edge();
    chk(count == c1, "R1 bit stays cleared in reset", count, c1);
    @(negedge wr_clk) wr_rst_n = 1'b1;
  endtask

  task automatic t_dst_reset();
    load(1'b1);
    drop_en();
    repeat (10) dst_edge();
    @(negedge dst_clk) dst_rst_n = 1'b0;
    #1;
    chk(count == 0, "R2 count cleared by destination reset", count, 0);
    @(negedge dst_clk) dst_rst_n = 1'b1;
    dst_edge();
    chk(count == 0, "R2 edge 1 after release", count, 0);
    dst_edge();
    chk(count == 0, "R2 edge 2 after release", count, 0);
    dst_edge();
    chk(count == 1, "R2 edge 3 after release", count, 1);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    t_reset();
    t_set();
    t_steady_ignore();
    t_clear();
    t_pulse();
    t_wr_reset();
    t_dst_reset();
    report();
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end

endmodule